// File: doc/BRIEF.md
# Task-Driven Timer/Counter with Compare-Clear

This block is a peripheral timer whose counter is driven by single-cycle task pulses. It raises single-cycle compare event pulses. A 2-bit mode input selects its behaviour. In timer mode the counter advances on a prescaled tick derived from the base clock. In the two counter modes it advances once for each count task.

Each channel has a capture/compare register. A capture task copies the live count into that register. When a compare hits on a channel that has its shortcut bit set, the counter returns to zero, so a channel loaded with N produces a periodic event every N ticks.

The block also drives a clock-request output. In timer mode and in legacy counter mode it stays high while the block is started. In low-power counter mode it is high only in the cycles where a count is taken.

Top module: `task_timer`

## Requirements
- R1: `mode_i` encoding is as follows: 0 selects timer, 1 selects legacy counter, 2 selects low-power counter, and 3 is reserved. In reserved mode the counter never advances and `clk_req_o` stays low.
- R2: In timer mode while started, the counter advances once every 2^`prescaler_i` clock cycles. The first advance comes 2^`prescaler_i` cycles after the edge that registered START.
- R3: START sets the running state and STOP clears it. STOP wins when both arrive together, and it blocks any advance in its own cycle. While the block is stopped, count tasks and ticks leave the counter unchanged.
- R4: CLEAR sets the counter to zero at the next edge, whether the block is running or stopped. It also wins over an advance in the same cycle.
- R5: In either counter mode while started, each cycle with `count_i` high advances the counter by exactly one.
- R6: When an advance produces a value equal to CC[n] (masked to the active width), `compare_o[n]` is high for one cycle, in the cycle that follows that edge.
- R7: When `shorts_i[n]` is set and CC[n] = N, the compare hit loads zero instead of N. The counter therefore runs 0..N-1, and the event period is N ticks.
- R8: `width_sel_i` values 0/1/2/3 give an 8/16/24/32-bit counter. The counter wraps from its maximum value to zero.
- R9: `capture_i[n]` loads the counter value from before the same edge into CC[n]. It wins over a `cc_we_i[n]` write in the same cycle. CC[n] is visible on `cc_o[n*CNT_W +: CNT_W]`.
- R10: `clk_req_o` follows the mode. In timer and legacy counter modes it equals the running state. In low-power mode it is high only in a cycle where a count is accepted (started, `count_i` high, no STOP).
- R11: After reset the outputs are as follows: the counter, all CC registers and `compare_o` are zero, the block is stopped, and `clk_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode |
| prescaler_i | input | PRESC_W | Tick divider exponent |
| width_sel_i | input | 2 | Counter width select |
| shorts_i | input | NUM_CH | Per-channel compare-to-clear enable |
| start_i | input | 1 | START task pulse |
| stop_i | input | 1 | STOP task pulse |
| clear_i | input | 1 | CLEAR task pulse |
| count_i | input | 1 | COUNT task pulse |
| capture_i | input | NUM_CH | Per-channel CAPTURE task pulses |
| cc_we_i | input | NUM_CH | Per-channel CC write enable |
| cc_wdata_i | input | CNT_W | CC write data |
| count_o | output | CNT_W | Current counter value |
| cc_o | output | NUM_CH*CNT_W | All CC registers, channel 0 in the low bits |
| compare_o | output | NUM_CH | Per-channel compare event pulses |
| clk_req_o | output | 1 | Fast clock request |

## Verification
The bench builds the block with its default parameters: four channels, a 32-bit counter and a 4-bit prescaler exponent. It selects the 8-bit width at run time, so a full wrap and the compare hit at zero take only a few hundred count pulses. A prescaler exponent of 2 shows the divided tick and its first-advance latency within a dozen cycles. A CC value of 4 on channel 0 shows the shortcut period repeating three times.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_TIMER  = 2'd0,
    TT_LEGACY = 2'd1,
    TT_LOWPWR = 2'd2,
    TT_RSVD   = 2'd3
  } tt_mode_e;

  function automatic logic [31:0] width_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      2'd2:    width_mask = 32'h00FF_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PRESC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [PRESC_W-1:0] exp_i,
  output logic               tick_o
);
  localparam int DIV_W = (1 << PRESC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  always_comb lim = ~({DIV_W{1'b1}} << exp_i);
  assign tick_o = run_i && (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= tick_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tt_channel.sv
module tt_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic [CNT_W-1:0] cc_o,
  output logic             hit_o,
  output logic             cmp_o
);
  logic [CNT_W-1:0] cc_q;

  assign hit_o = inc_i && !clr_i && (nxt_i == (cc_q & mask_i));
  assign cc_o  = cc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q  <= '0;
      cmp_o <= 1'b0;
    end else begin
      cmp_o <= hit_o;
      if (cap_i)     cc_q <= cnt_i;   // capture beats write
      else if (we_i) cc_q <= wdata_i;
    end
  end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
  import tt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       width_sel_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic             count_i,
  input  logic             tick_i,
  input  logic             short_hit_i,
  output logic             running_o,
  output logic             inc_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] mask_o,
  output logic [CNT_W-1:0] count_o,
  output logic             clk_req_o
);
  tt_mode_e         mode;
  logic             run_q;
  logic             src;
  logic [CNT_W-1:0] cnt_q;

  assign mode   = tt_mode_e'(mode_i);
  assign mask_o = CNT_W'(width_mask(width_sel_i));

  always_comb begin
    case (mode)
      TT_TIMER:            src = tick_i;
      TT_LEGACY, TT_LOWPWR: src = count_i;
      default:             src = 1'b0;
    endcase
  end

  assign inc_o     = run_q && !stop_i && src;
  assign nxt_o     = (cnt_q + 1'b1) & mask_o;
  assign running_o = run_q;
  assign count_o   = cnt_q;

  always_comb begin
    case (mode)
      TT_TIMER, TT_LEGACY: clk_req_o = run_q;
      TT_LOWPWR:           clk_req_o = inc_o;
      default:             clk_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
      if (clear_i)      cnt_q <= '0;
      else if (inc_o)   cnt_q <= short_hit_i ? '0 : nxt_o;
    end
  end
endmodule

// File: rtl/task_timer.sv
module task_timer #(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic [PRESC_W-1:0]      prescaler_i,
  input  logic [1:0]              width_sel_i,
  input  logic [NUM_CH-1:0]       shorts_i,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    clear_i,
  input  logic                    count_i,
  input  logic [NUM_CH-1:0]       capture_i,
  input  logic [NUM_CH-1:0]       cc_we_i,
  input  logic [CNT_W-1:0]        cc_wdata_i,
  output logic [CNT_W-1:0]        count_o,
  output logic [NUM_CH*CNT_W-1:0] cc_o,
  output logic [NUM_CH-1:0]       compare_o,
  output logic                    clk_req_o
);
  logic             running;
  logic             tick;
  logic             inc;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] mask;
  logic [NUM_CH-1:0] hit;
  logic             short_hit;

  assign short_hit = |(hit & shorts_i);

  tt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .restart_i (start_i | clear_i),
    .exp_i     (prescaler_i),
    .tick_o    (tick)
  );

  tt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .width_sel_i (width_sel_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .clear_i     (clear_i),
    .count_i     (count_i),
    .tick_i      (tick),
    .short_hit_i (short_hit),
    .running_o   (running),
    .inc_o       (inc),
    .nxt_o       (nxt),
    .mask_o      (mask),
    .count_o     (count_o),
    .clk_req_o   (clk_req_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cc_we_i[g]),
      .wdata_i (cc_wdata_i),
      .cap_i   (capture_i[g]),
      .cnt_i   (count_o),
      .inc_i   (inc),
      .clr_i   (clear_i),
      .nxt_i   (nxt),
      .mask_i  (mask),
      .cc_o    (cc_o[g*CNT_W +: CNT_W]),
      .hit_o   (hit[g]),
      .cmp_o   (compare_o[g])
    );
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [NUM_CH-1:0] shorts_i,
  input logic              stop_i,
  input logic              clear_i,
  input logic              count_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [NUM_CH-1:0] compare_o,
  input logic              clk_req_o
);
  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));

  a_r3_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clear_i) |=> $stable(count_o));

  a_r1_rsvd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !clear_i) |=> $stable(count_o));

  a_r1_rsvd_noreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> !clk_req_o);

  a_r10_lp_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !count_i) |-> !clk_req_o);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    a_r7_short_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (compare_o[g] && $past(shorts_i[g])) |-> (count_o == '0));
  end
endmodule

bind task_timer tt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_tt_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .shorts_i  (shorts_i),
  .stop_i    (stop_i),
  .clear_i   (clear_i),
  .count_i   (count_i),
  .count_o   (count_o),
  .compare_o (compare_o),
  .clk_req_o (clk_req_o)
);

// File: tb/tb_task_timer.sv
`timescale 1ns/1ps
module tb_task_timer;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 32;
  localparam int PW     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [PW-1:0] presc = '0;
  logic [1:0] wsel = 2'd3;
  logic [NUM_CH-1:0] shorts = '0;
  logic start = 0, stop = 0, clr = 0, cnt = 0;
  logic [NUM_CH-1:0] cap = '0, we = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] count;
  logic [NUM_CH*CNT_W-1:0] cc;
  logic [NUM_CH-1:0] cmp;
  logic req;

  always #4 clk = ~clk;

  task_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRESC_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .prescaler_i(presc),
    .width_sel_i(wsel), .shorts_i(shorts), .start_i(start), .stop_i(stop),
    .clear_i(clr), .count_i(cnt), .capture_i(cap), .cc_we_i(we),
    .cc_wdata_i(wdata), .count_o(count), .cc_o(cc), .compare_o(cmp),
    .clk_req_o(req)
  );

  typedef struct {int kind; int idx; logic [31:0] exp; string req;} item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic expect_item(input int kind, input int idx, input logic [31:0] e, input string r);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  // monitor: samples 2 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = count;
          1: act = 32'(cmp);
          2: act = 32'(req);
          default: act = cc[it.idx*CNT_W +: CNT_W];
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    start = 0; stop = 0; clr = 0; cnt = 0; cap = '0; we = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    expect_item(0, 0, 0, "R11 count");
    expect_item(1, 0, 0, "R11 compare");
    expect_item(2, 0, 0, "R11 clk_req");
    expect_item(3, 0, 0, "R11 cc0");
    tick(); we = 4'b0001; wdata = 32'd4;

    // R7/R6 period of 4 with shortcut, timer p=0 (R2)
    tick(); shorts = 4'b0001; start = 1;
    for (int k = 1; k <= 12; k++) begin
      tick();
      expect_item(0, 0, 32'((k-1) % 4), "R7 period count");
      expect_item(1, 0, (k > 1 && (k-1) % 4 == 0) ? 32'd1 : 32'd0, "R6 compare pulse");
    end
    expect_item(2, 0, 1, "R10 timer req running");
    tick(); stop = 1;
    tick();
    expect_item(0, 0, 0, "R3 stop blocks advance");
    expect_item(2, 0, 0, "R10 timer req stopped");

    // R4 clear while stopped
    tick(); start = 1;
    tick(); tick(); tick();
    tick(); stop = 1;
    tick();
    expect_item(0, 0, 3, "R3 hold after stop");
    tick(); clr = 1;
    tick();
    expect_item(0, 0, 0, "R4 clear while stopped");

    // R2 prescaler exponent 2
    shorts = '0; presc = 4'd2;
    tick(); start = 1;
    for (int k = 1; k <= 12; k++) begin
      tick();
      expect_item(0, 0, 32'((k-1) / 4), "R2 prescaled tick");
    end
    tick(); stop = 1;
    tick(); clr = 1;
    presc = '0;

    // R5 legacy counter, R3 ignore while stopped
    mode = 2'd1;
    tick(); cnt = 1;
    tick();
    expect_item(0, 0, 0, "R3 count ignored stopped");
    expect_item(2, 0, 0, "R10 legacy req stopped");
    tick(); start = 1;
    tick();
    expect_item(2, 0, 1, "R10 legacy req running");
    for (int i = 0; i < 3; i++) begin
      tick(); cnt = 1;
      tick();
    end
    tick();
    expect_item(0, 0, 3, "R5 one per count");
    expect_item(2, 0, 1, "R10 legacy req idle");

    // R4 clear beats advance, R9 capture pre-update
    tick(); cnt = 1; clr = 1; cap = 4'b0100;
    tick();
    expect_item(0, 0, 0, "R4 clear wins");
    expect_item(3, 2, 3, "R9 capture pre-update");
    tick(); cnt = 1;
    tick(); cnt = 1; cap = 4'b1000; we = 4'b1000; wdata = 32'h99;
    tick();
    expect_item(3, 3, 1, "R9 capture beats write");
    expect_item(0, 0, 2, "R5 count after capture");

    // R10 low-power request
    mode = 2'd2;
    tick(); cnt = 1;
    expect_item(2, 0, 1, "R10 lp req on count");
    tick();
    expect_item(2, 0, 0, "R10 lp req idle");
    expect_item(0, 0, 3, "R5 lp count");

    // R1 reserved mode
    mode = 2'd3;
    tick(); cnt = 1;
    expect_item(2, 0, 0, "R1 reserved no req");
    tick();
    expect_item(0, 0, 3, "R1 reserved holds");

    // R8 8-bit wrap, R6 hit at zero on channel 1
    mode = 2'd1; wsel = 2'd0;
    tick(); clr = 1;
    for (int i = 0; i < 255; i++) begin
      tick(); cnt = 1;
    end
    tick();
    expect_item(0, 0, 255, "R8 max 8-bit");
    expect_item(1, 0, 0, "R6 no compare before wrap");
    cnt = 1;
    tick();
    expect_item(0, 0, 0, "R8 wrap to zero");
    expect_item(1, 0, 32'b0010, "R6 compare on wrap");
    tick();
    expect_item(1, 0, 0, "R6 single-cycle pulse");
    tick(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule